// File: doc/BRIEF.md
# Selectable GPIO Interrupt Router

The router takes a wide vector of GPIO interrupt lines and maps them onto a fixed set of interrupt slots. Each slot picks one GPIO line at run time through a 7-bit source selector, watches it for a programmed condition (a rising edge, a falling edge, a high level or a low level) and records the result in a per-slot status flag. Every slot drives one level-high request towards a parent interrupt controller. That request is active while the slot's flag is set and the slot is enabled.

Software programs the router over a simple 32-bit register bus. Four slots share each selector register, with one byte per slot. Sixteen slots share each sense register, with two bits per slot. Software reads the flags from a status register and acknowledges edge events through a write-one-to-clear register. Level flags follow their source, so the clear register leaves them alone. To reconfigure a slot safely, software clears its enable, writes the new selector and the new sense mode, clears any stale flag and then enables the slot again. The edge detector keeps sampling the selected line while the slot is disabled, so enabling the slot with the line already high does not raise a false edge.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset all selectors, enables, sense fields and flags are zero. Every register reads 0 and `irq_o` is all zero.
- R2: The selector register at byte offset 0x30+4k holds slots 4k..4k+3. For slot 4k+n, byte n holds the source index in bits 6:0 and the enable in bit 7. A written value reads back unchanged one cycle after the read strobe.
- R3: The sense register at 0x28+4k holds slots 16k..16k+15, with 2 bits per slot at bit 2n. The codes are 0 = rising edge, 1 = falling edge, 2 = high level and 3 = low level. A written value reads back unchanged.
- R4: In rising mode, an enabled slot sets its flag on the clock edge where the selected line is sampled 1 after having been 0. The flag stays set after the line falls.
- R5: In falling mode, an enabled slot sets its flag on a 1-to-0 transition of the selected line. A rising transition does not set it.
- R6: In high-level mode an enabled slot's flag equals the line sampled on the previous clock. In low-level mode it equals the inverse of that line.
- R7: Writing 1 to bit n of the clear register at 0x24 clears flag n only in an edge mode. In a level mode the write has no effect. If an edge and a clear reach a slot in the same cycle, the flag stays set.
- R8: A selector value above 85 (0x55) selects no line, and the slot sees a constant 0. Edge modes never fire, and low-level mode is always active.
- R9: While a slot is disabled its flag does not change except through the clear register. Re-enabling a rising-mode slot whose line is already high does not set the flag.
- R10: The status register at 0x20 returns flag n in bit n. `irq_o[n]` is flag n AND enable n, so a disabled slot holding a flag drives no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Byte address; bits 1:0 are ignored |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| gpio_int_i | input | 86 | GPIO interrupt source lines |
| irq_o | output | 32 | Level-high requests to the parent controller |

## Verification
The hardest situation to reach from the ports is a slot's edge detector seeing a transition while the slot is disabled, followed by re-enabling with the line already at its active level. A wrong design raises a false edge in that case. The bench disables a slot, pulses and then holds its line high, and re-enables the slot. It then checks both the status word and the request line. A second hard case is an edge and a clear write landing in the same cycle, which the bench forces by driving the line change and the clear strobe on the same edge. A random phase then mixes selector, sense and clear writes with line toggles, and compares every request against a behavioural model on every clock.

// File: rtl/gir_pkg.sv
package gir_pkg;
   typedef enum logic [1:0] {
      SENSE_RISE = 2'd0,
      SENSE_FALL = 2'd1,
      SENSE_HIGH = 2'd2,
      SENSE_LOW  = 2'd3
   } sense_e;

   localparam int STAT_OFF   = 'h20;
   localparam int CLR_OFF    = 'h24;
   localparam int SENSE_BASE = 'h28;
   localparam int SEL_BASE   = 'h30;
   localparam int LANE_W     = 8;
   localparam int MODE_W     = 2;
endpackage

// File: rtl/gir_slot.sv
module gir_slot
   import gir_pkg::*;
#(
   parameter int NUM_SRC = 86,
   parameter int MAX_SRC = 85,
   parameter int SEL_W   = 7
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [SEL_W-1:0]   sel_i,
   input  logic               en_i,
   input  sense_e             mode_i,
   input  logic               clr_i,
   output logic               hit_o,
   output logic               prev_o,
   output logic               flag_o,
   output logic               irq_o
);
   logic hit, prev_q, flag_q, edge_mode, edge_evt;

   // source multiplexer; selectors past MAX_SRC match nothing
   always_comb begin
      hit = 1'b0;
      for (int s = 0; s <= MAX_SRC; s++) begin
         if (sel_i == SEL_W'(s)) hit = src_i[s];
      end
   end

   assign edge_mode = (mode_i == SENSE_RISE) || (mode_i == SENSE_FALL);
   assign edge_evt  = en_i && (((mode_i == SENSE_RISE) &&  hit && !prev_q) ||
                               ((mode_i == SENSE_FALL) && !hit &&  prev_q));

   // previous-value register samples regardless of enable
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= hit;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= 1'b0;
      end else if (en_i && (mode_i == SENSE_HIGH)) begin
         flag_q <= hit;
      end else if (en_i && (mode_i == SENSE_LOW)) begin
         flag_q <= !hit;
      end else if (edge_evt) begin
         flag_q <= 1'b1;
      end else if (clr_i && edge_mode) begin
         flag_q <= 1'b0;
      end
   end

   assign hit_o  = hit;
   assign prev_o = prev_q;
   assign flag_o = flag_q;
   assign irq_o  = flag_q & en_i;
endmodule

// File: rtl/gir_regs.sv
module gir_regs
   import gir_pkg::*;
#(
   parameter int NUM_SLOTS = 32,
   parameter int SEL_W     = 7,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int RD_LAT    = 1
) (
   input  logic                             clk_i,
   input  logic                             rst_ni,
   input  logic                             wr_i,
   input  logic                             rd_i,
   input  logic [ADDR_W-1:0]                addr_i,
   input  logic [DATA_W-1:0]                wdata_i,
   output logic [DATA_W-1:0]                rdata_o,
   input  logic [NUM_SLOTS-1:0]             flags_i,
   output logic [NUM_SLOTS-1:0][SEL_W-1:0]  sel_o,
   output logic [NUM_SLOTS-1:0]             en_o,
   output logic [NUM_SLOTS-1:0][MODE_W-1:0] mode_o,
   output logic [NUM_SLOTS-1:0]             clr_o
);
   localparam int SPS        = DATA_W / LANE_W;
   localparam int SPR        = DATA_W / MODE_W;
   localparam int STAT_WORD  = STAT_OFF / 4;
   localparam int CLR_WORD   = CLR_OFF / 4;
   localparam int SENSE_WORD = SENSE_BASE / 4;
   localparam int SEL_WORD   = SEL_BASE / 4;

   logic [NUM_SLOTS-1:0][SEL_W-1:0]  sel_q;
   logic [NUM_SLOTS-1:0]             en_q;
   logic [NUM_SLOTS-1:0][MODE_W-1:0] mode_q;
   logic [DATA_W-1:0]                rd_word;
   int                               wa;
   logic                             unused_lo;

   assign wa        = int'(addr_i[ADDR_W-1:2]);
   assign unused_lo = ^{addr_i[1:0], rd_i};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q  <= '0;
         en_q   <= '0;
         mode_q <= '0;
      end else if (wr_i) begin
         for (int s = 0; s < NUM_SLOTS; s++) begin
            if (wa == SEL_WORD + s / SPS) begin
               sel_q[s] <= wdata_i[LANE_W*(s%SPS) +: SEL_W];
               en_q[s]  <= wdata_i[LANE_W*(s%SPS) + LANE_W - 1];
            end
            if (wa == SENSE_WORD + s / SPR)
               mode_q[s] <= wdata_i[MODE_W*(s%SPR) +: MODE_W];
         end
      end
   end

   always_comb begin
      clr_o = '0;
      if (wr_i && (wa == CLR_WORD)) clr_o = wdata_i[NUM_SLOTS-1:0];
   end

   always_comb begin
      rd_word = '0;
      if (wa == STAT_WORD) rd_word[NUM_SLOTS-1:0] = flags_i;
      for (int s = 0; s < NUM_SLOTS; s++) begin
         if (wa == SENSE_WORD + s / SPR)
            rd_word[MODE_W*(s%SPR) +: MODE_W] = mode_q[s];
         if (wa == SEL_WORD + s / SPS) begin
            rd_word[LANE_W*(s%SPS) +: SEL_W]      = sel_q[s];
            rd_word[LANE_W*(s%SPS) + LANE_W - 1] = en_q[s];
         end
      end
   end

   generate
      if (RD_LAT == 1) begin : g_rd_reg
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)   rdata_q <= '0;
            else if (rd_i) rdata_q <= rd_word;
         end
         assign rdata_o = rdata_q;
      end else begin : g_rd_comb
         assign rdata_o = rd_word;
      end
   endgenerate

   assign sel_o  = sel_q;
   assign en_o   = en_q;
   assign mode_o = mode_q;
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
   import gir_pkg::*;
#(
   parameter int NUM_SLOTS = 32,
   parameter int NUM_SRC   = 86,
   parameter int MAX_SRC   = 85,
   parameter int SEL_W     = 7,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 8,
   parameter int RD_LAT    = 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               bus_wr_i,
   input  logic               bus_rd_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   output logic [DATA_W-1:0]  bus_rdata_o,
   input  logic [NUM_SRC-1:0] gpio_int_i,
   output logic [NUM_SLOTS-1:0] irq_o
);
   localparam int SPS     = DATA_W / LANE_W;
   localparam int SPR     = DATA_W / MODE_W;
   localparam int N_SEL   = NUM_SLOTS / SPS;
   localparam int N_SENSE = NUM_SLOTS / SPR;

   // elaboration-time parameter checks
   generate
      if (MAX_SRC >= NUM_SRC) begin : g_bad_max
         $error("MAX_SRC must index a real source");
      end
      if (NUM_SRC > (1 << SEL_W)) begin : g_bad_sel
         $error("SEL_W too narrow for NUM_SRC");
      end
      if (SEL_W > LANE_W - 1) begin : g_bad_lane
         $error("selector and enable must share one byte");
      end
      if (NUM_SLOTS > DATA_W || (NUM_SLOTS % SPR) != 0) begin : g_bad_slots
         $error("NUM_SLOTS must fill whole sense registers and fit one word");
      end
      if (SENSE_BASE + 4 * N_SENSE > SEL_BASE ||
          SEL_BASE + 4 * N_SEL > (1 << ADDR_W)) begin : g_bad_map
         $error("register windows overlap or exceed the address space");
      end
      if (RD_LAT != 0 && RD_LAT != 1) begin : g_bad_lat
         $error("RD_LAT must be 0 or 1");
      end
   endgenerate

   logic [NUM_SLOTS-1:0][SEL_W-1:0]  slot_sel;
   logic [NUM_SLOTS-1:0]             slot_en;
   logic [NUM_SLOTS-1:0][MODE_W-1:0] slot_mode;
   logic [NUM_SLOTS-1:0]             slot_clr;
   logic [NUM_SLOTS-1:0]             slot_hit;
   logic [NUM_SLOTS-1:0]             slot_prev;
   logic [NUM_SLOTS-1:0]             slot_flag;

   gir_regs #(
      .NUM_SLOTS (NUM_SLOTS),
      .SEL_W     (SEL_W),
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .RD_LAT    (RD_LAT)
   ) regs_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (bus_wr_i),
      .rd_i    (bus_rd_i),
      .addr_i  (bus_addr_i),
      .wdata_i (bus_wdata_i),
      .rdata_o (bus_rdata_o),
      .flags_i (slot_flag),
      .sel_o   (slot_sel),
      .en_o    (slot_en),
      .mode_o  (slot_mode),
      .clr_o   (slot_clr)
   );

   generate
      for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
         gir_slot #(
            .NUM_SRC (NUM_SRC),
            .MAX_SRC (MAX_SRC),
            .SEL_W   (SEL_W)
         ) slot_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .src_i  (gpio_int_i),
            .sel_i  (slot_sel[g]),
            .en_i   (slot_en[g]),
            .mode_i (sense_e'(slot_mode[g])),
            .clr_i  (slot_clr[g]),
            .hit_o  (slot_hit[g]),
            .prev_o (slot_prev[g]),
            .flag_o (slot_flag[g]),
            .irq_o  (irq_o[g])
         );
      end
   endgenerate
endmodule

// File: rtl/gir_checker.sv
module gir_checker #(
   parameter int NS      = 32,
   parameter int SEL_W   = 7,
   parameter int MAX_SRC = 85
) (
   input logic                    clk_i,
   input logic                    rst_ni,
   input logic [NS-1:0][SEL_W-1:0] slot_sel,
   input logic [NS-1:0]           slot_en,
   input logic [NS-1:0][1:0]      slot_mode,
   input logic [NS-1:0]           slot_clr,
   input logic [NS-1:0]           slot_hit,
   input logic [NS-1:0]           slot_prev,
   input logic [NS-1:0]           slot_flag
);
   localparam logic [SEL_W-1:0] TOP_SEL = SEL_W'(MAX_SRC);

   generate
      for (genvar i = 0; i < NS; i++) begin : g_chk
         a_r4_rise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (slot_en[i] && slot_mode[i] == 2'd0 && slot_hit[i] && !slot_prev[i]) |=> slot_flag[i]);
         a_r5_fall_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (slot_en[i] && slot_mode[i] == 2'd1 && !slot_hit[i] && slot_prev[i]) |=> slot_flag[i]);
         a_r6_high_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (slot_en[i] && slot_mode[i] == 2'd2) |=> (slot_flag[i] == $past(slot_hit[i])));
         a_r6_low_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (slot_en[i] && slot_mode[i] == 2'd3) |=> (slot_flag[i] != $past(slot_hit[i])));
         a_r7_level_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (slot_en[i] && slot_mode[i] == 2'd2 && slot_hit[i] && slot_clr[i]) |=> slot_flag[i]);
         a_r8_bad_sel_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (slot_sel[i] > TOP_SEL) |-> !slot_hit[i]);
         a_r9_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!slot_en[i] && !slot_clr[i]) |=> $stable(slot_flag[i]));
      end
   endgenerate
endmodule

bind gpio_irq_router gir_checker #(
   .NS      (NUM_SLOTS),
   .SEL_W   (SEL_W),
   .MAX_SRC (MAX_SRC)
) chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .slot_sel  (slot_sel),
   .slot_en   (slot_en),
   .slot_mode (slot_mode),
   .slot_clr  (slot_clr),
   .slot_hit  (slot_hit),
   .slot_prev (slot_prev),
   .slot_flag (slot_flag)
);

// File: tb/gpio_irq_router_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_router_tb_top;
   localparam int NS   = 32;
   localparam int NSRC = 86;
   localparam int MAXS = 85;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]      bus_addr = '0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [NSRC-1:0] src = '0;
   logic [NS-1:0]   irq;

   always #2 clk = ~clk;

   gpio_irq_router dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .bus_wr_i    (bus_wr),
      .bus_rd_i    (bus_rd),
      .bus_addr_i  (bus_addr),
      .bus_wdata_i (bus_wdata),
      .bus_rdata_o (bus_rdata),
      .gpio_int_i  (src),
      .irq_o       (irq)
   );

   int total = 0, bad = 0;
   bit done = 1'b0;

   // behavioural reference model
   int m_sel[NS];
   bit m_en[NS];
   int m_mode[NS];
   bit m_flag[NS];
   bit m_prev[NS];

   function automatic logic [31:0] m_status();
      logic [31:0] v = '0;
      for (int s = 0; s < NS; s++) v[s] = m_flag[s];
      return v;
   endfunction

   function automatic logic [31:0] m_irq();
      logic [31:0] v = '0;
      for (int s = 0; s < NS; s++) v[s] = m_flag[s] & m_en[s];
      return v;
   endfunction

   always @(posedge clk) begin
      bit hit, clr;
      if (!rst_n) begin
         for (int s = 0; s < NS; s++) begin
            m_sel[s] = 0; m_en[s] = 0; m_mode[s] = 0; m_flag[s] = 0; m_prev[s] = 0;
         end
      end else begin
         for (int s = 0; s < NS; s++) begin
            hit = (m_sel[s] <= MAXS) ? src[m_sel[s]] : 1'b0;
            clr = bus_wr && bus_addr == 8'h24 && bus_wdata[s];
            if (m_en[s] && m_mode[s] == 2)      m_flag[s] = hit;
            else if (m_en[s] && m_mode[s] == 3) m_flag[s] = !hit;
            else if (m_en[s] && m_mode[s] == 0 && hit && !m_prev[s]) m_flag[s] = 1;
            else if (m_en[s] && m_mode[s] == 1 && !hit && m_prev[s]) m_flag[s] = 1;
            else if (clr && m_mode[s] < 2) m_flag[s] = 0;
            m_prev[s] = hit;
         end
         if (bus_wr && (bus_addr == 8'h28 || bus_addr == 8'h2C)) begin
            for (int n = 0; n < 16; n++)
               m_mode[16 * ((bus_addr - 8'h28) / 4) + n] = int'(bus_wdata[2*n +: 2]);
         end
         if (bus_wr && bus_addr >= 8'h30 && bus_addr <= 8'h4C) begin
            for (int n = 0; n < 4; n++) begin
               m_sel[4 * ((bus_addr - 8'h30) / 4) + n] = int'(bus_wdata[8*n +: 7]);
               m_en[4 * ((bus_addr - 8'h30) / 4) + n]  = bus_wdata[8*n + 7];
            end
         end
      end
   end

   // R10: every request compared with the model on every clock
   always @(negedge clk) begin
      if (rst_n && !done) begin
         total++;
         if (irq !== m_irq()) begin
            bad++;
            $display("FAIL R10 irq act=%h exp=%h t=%0t", irq, m_irq(), $time);
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(8'h20, d); check("R1 status", d, 32'h0);
      rd(8'h28, d); check("R1 sense0", d, 32'h0);
      rd(8'h4C, d); check("R1 sel7", d, 32'h0);
      check("R1 irq", irq, 32'h0);

      // R2 selector layout
      wr(8'h30, 32'hD5028185);
      rd(8'h30, d); check("R2 sel0 readback", d, 32'hD5028185);
      wr(8'h4C, 32'hFF7F0000);
      rd(8'h4C, d); check("R2 sel7 readback", d, 32'hFF7F0000);
      wr(8'h4C, 32'h0);

      // R3 sense layout: slot0 rise, slot1 fall, slot2 high, slot3 low
      wr(8'h28, 32'h000000E4);
      rd(8'h28, d); check("R3 sense0 readback", d, 32'h000000E4);
      wr(8'h2C, 32'hA5A50000);
      rd(8'h2C, d); check("R3 sense1 readback", d, 32'hA5A50000);
      wr(8'h2C, 32'h0);
      idle(1);
      rd(8'h20, d); check("R6 low level on idle line", d, 32'h8);

      // R4 rising edge on line 5 -> slot0
      src[5] = 1'b1; idle(2);
      check("R4 rise sets", 32'(irq[0]), 32'h1);
      src[5] = 1'b0; idle(2);
      check("R4 flag sticky", 32'(irq[0]), 32'h1);
      wr(8'h24, 32'h1); idle(1);
      check("R7 edge clear", 32'(irq[0]), 32'h0);

      // R5 falling edge on line 1 -> slot1
      src[1] = 1'b1; idle(2);
      check("R5 rise ignored", 32'(irq[1]), 32'h0);
      src[1] = 1'b0; idle(2);
      check("R5 fall sets", 32'(irq[1]), 32'h1);
      wr(8'h24, 32'h2); idle(1);
      check("R7 fall clear", 32'(irq[1]), 32'h0);

      // R6 level modes
      wr(8'h30, 32'hD5828185);
      src[2] = 1'b1; idle(2);
      check("R6 high active", 32'(irq[2]), 32'h1);
      src[2] = 1'b0; idle(2);
      check("R6 high released", 32'(irq[2]), 32'h0);
      src[85] = 1'b1; idle(2);
      check("R6 low released", 32'(irq[3]), 32'h0);
      src[85] = 1'b0; idle(2);
      check("R6 low active", 32'(irq[3]), 32'h1);

      // R7 clear ignored in level mode
      wr(8'h24, 32'h8); idle(1);
      check("R7 level clear ignored", 32'(irq[3]), 32'h1);

      // R7 edge and clear in the same cycle: flag stays
      src[5] = 1'b1; bus_wr = 1'b1; bus_addr = 8'h24; bus_wdata = 32'h1;
      @(negedge clk);
      bus_wr = 1'b0;
      idle(1);
      check("R7 set beats clear", 32'(irq[0]), 32'h1);
      src[5] = 1'b0; wr(8'h24, 32'h1); idle(1);

      // R9 disabled slot holds; no false edge on re-enable
      wr(8'h30, 32'hD5828105);
      src[5] = 1'b1; idle(2);
      src[5] = 1'b0; idle(2);
      rd(8'h20, d); check("R9 disabled no flag", d & 32'h1, 32'h0);
      src[5] = 1'b1; idle(2);
      wr(8'h30, 32'hD5828185); idle(2);
      check("R9 no false edge", 32'(irq[0]), 32'h0);
      src[5] = 1'b0; idle(1);
      src[5] = 1'b1; idle(2);
      check("R9 edge after enable", 32'(irq[0]), 32'h1);
      wr(8'h24, 32'h1);

      // R10 disabled slot keeps flag but drives no request
      wr(8'h30, 32'h55828185); idle(1);
      rd(8'h20, d); check("R10 status holds flag", d & 32'h8, 32'h8);
      check("R10 request gated", 32'(irq[3]), 32'h0);

      // R8 out-of-range selectors
      wr(8'h34, 32'h0000FFD6);
      src = '1; idle(2);
      src = '0; idle(2);
      check("R8 bad sel edge quiet", 32'(irq[5:4]), 32'h0);
      wr(8'h28, 32'h000003E4); idle(2);
      check("R8 bad sel low level", 32'(irq[4]), 32'h1);

      // random phase, checked every clock by the model (R4 R5 R6 R7 R10)
      for (int it = 0; it < 4000; it++) begin
         int act;
         act = $urandom_range(0, 15);
         if ($urandom_range(0, 1) == 1) src[$urandom_range(0, NSRC-1)] ^= 1'b1;
         if (act == 0) begin
            logic [31:0] w;
            for (int n = 0; n < 4; n++)
               w[8*n +: 8] = {1'($urandom_range(0, 1)), 7'($urandom_range(0, 8'h5F))};
            wr(8'h30 + 8'(4 * $urandom_range(0, 7)), w);
         end else if (act == 1) begin
            wr(8'h28 + 8'(4 * $urandom_range(0, 1)), $urandom);
         end else if (act == 2) begin
            wr(8'h24, $urandom);
         end else if (act == 3) begin
            logic [31:0] e;
            e = m_status();
            rd(8'h20, d); check("R10 status random", d, e);
         end else begin
            idle(1);
         end
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule